// File: doc/BRIEF.md
# Three-Level Space-Vector Sequencer with Neutral-Point Trim

This block sits between a modulator that has already worked out which sector the reference lies in and how long each of three vectors should be applied, and the gate drivers of a three-phase, three-level neutral-point-clamped bridge. Once per sampling period it takes a region code, three dwell times in clock cycles and two comparator flags describing the midpoint capacitor voltage. It then plays out a fixed three-vector sequence and turns each vector into twelve switch commands, four per phase.

Each region's sequence starts with a lower small vector, so vectors that charge and discharge the midpoint alternate from period to period. When one flag reports that the midpoint has drifted toward a rail, the block moves up to a programmable number of cycles between the upper-small and lower-small dwells. The total length of the period does not change. A dwell of zero skips its vector outright. A new period can start on the clock edge that ends the previous one, so the carrier period stays constant.

Top module: `npc_vector_seq`

## Requirements
- R1: A synchronous reset sets every phase to the neutral level (vector [000], gates 0110 on each phase) and clears `done`. While no period is running, the output stays at [000].
- R2: Phase level codes on `levels` are 2'b01 for '+', 2'b00 for '0' and 2'b10 for '-'. Phase U is in bits 5:4, V in 3:2 and W in 1:0. Each phase drives {S1,S2,S3,S4} on `gates` (U in 11:8, V in 7:4, W in 3:0): '+' gives 1100, '0' gives 0110 and '-' gives 0011. No phase ever moves directly between '+' and '-'.
- R3: Region 0 (and the unused code 3) plays [0-0], then [+00], then [000].
- R4: Region 1 plays [0-0], then [+-0], then [+00].
- R5: Region 2 plays [0-0], then [+0-], then [+--]. No trim is applied in this region.
- R6: Vector k is held for exactly `dwell_k` cycles. The first vector appears in the cycle after the load edge. The period therefore lasts the sum of the three dwells.
- R7: With only `np_hi` set, up to `delta` cycles move from the upper-small dwell to the lower-small dwell. With both flags set, or neither, no cycles move.
- R8: With only `np_lo` set, up to `delta` cycles move from the lower-small dwell to the upper-small dwell.
- R9: A trim never takes more cycles than the shortened dwell holds. That dwell stops at zero, and the other dwell grows only by the amount actually removed.
- R10: A zero dwell, whether given as input or produced by a trim, skips its vector without a one-cycle glitch. If all three dwells are zero, no vector is played.
- R11: `load` is accepted only when no period is running or in the final cycle of a period. At any other time it has no effect on the vectors being played.
- R12: `done` is high for one cycle after the last cycle of each period, and also after an accepted load whose dwells are all zero. A load accepted in the final cycle starts the next period with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe offering a new period |
| region | input | 2 | Region code selecting the vector sequence |
| dwell_a | input | 16 | Dwell of the first (lower-small) vector, cycles |
| dwell_b | input | 16 | Dwell of the second vector, cycles |
| dwell_c | input | 16 | Dwell of the third vector, cycles |
| delta | input | 16 | Maximum cycles moved by a neutral-point trim |
| np_hi | input | 1 | Midpoint too close to the upper rail |
| np_lo | input | 1 | Midpoint too close to the lower rail |
| levels | output | 6 | Current phase levels U,V,W |
| gates | output | 12 | Switch commands S1..S4 for U,V,W |
| done | output | 1 | Period-complete pulse |

## Verification
The hardest behaviour to reach is the seamless hand-over. A load must land in the single final cycle of a running period, and that period may itself be shortened by skipped vectors or a clamped trim. The bench watches its own reference queue and raises `load` exactly when one cycle of the current period remains. It chains periods of one-cycle dwells, zero dwells and clamped trims this way. It also offers loads in the middle of periods to show that they are refused.

// File: rtl/npc_vector_seq.sv
module npc_vector_seq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    region,
  input  logic [DW-1:0] dwell_a,
  input  logic [DW-1:0] dwell_b,
  input  logic [DW-1:0] dwell_c,
  input  logic [DW-1:0] delta,
  input  logic          np_hi,
  input  logic          np_lo,
  output logic [5:0]    levels,
  output logic [11:0]   gates,
  output logic          done
);

  localparam logic [1:0] LP = 2'b01, LZ = 2'b00, LN = 2'b10;

  function automatic logic [5:0] vec_of(input logic [1:0] rg, input logic [1:0] sl);
    case (rg)
      2'd1: case (sl)
              2'd0: vec_of = {LZ, LN, LZ};
              2'd1: vec_of = {LP, LN, LZ};
              default: vec_of = {LP, LZ, LZ};
            endcase
      2'd2: case (sl)
              2'd0: vec_of = {LZ, LN, LZ};
              2'd1: vec_of = {LP, LZ, LN};
              default: vec_of = {LP, LN, LN};
            endcase
      default: case (sl)
              2'd0: vec_of = {LZ, LN, LZ};
              2'd1: vec_of = {LP, LZ, LZ};
              default: vec_of = {LZ, LZ, LZ};
            endcase
    endcase
  endfunction

  logic          running;
  logic [1:0]    slot;
  logic [1:0]    rg_q;
  logic [DW-1:0] cnt, dw1, dw2;
  logic [5:0]    lev;

  logic          has_up, up_in_c, trim_hi, trim_lo;
  logic [DW-1:0] lo_in, up_in, take, lo_adj, up_adj;
  logic [DW-1:0] adj0, adj1, adj2;

  assign has_up  = region != 2'd2;
  assign up_in_c = region == 2'd1;
  assign trim_hi = has_up && np_hi && !np_lo;
  assign trim_lo = has_up && np_lo && !np_hi;
  assign lo_in   = dwell_a;
  assign up_in   = up_in_c ? dwell_c : dwell_b;

  always_comb begin
    take = '0;
    if (trim_hi)      take = (delta > up_in) ? up_in : delta;
    else if (trim_lo) take = (delta > lo_in) ? lo_in : delta;
    lo_adj = trim_hi ? lo_in + take : lo_in - take;
    up_adj = trim_hi ? up_in - take : up_in + take;
  end

  assign adj0 = lo_adj;
  assign adj1 = (has_up && !up_in_c) ? up_adj : dwell_b;
  assign adj2 = up_in_c ? up_adj : dwell_c;

  logic          first_ok;
  logic [1:0]    first_sl;
  logic [DW-1:0] first_dw;

  always_comb begin
    first_ok = 1'b1;
    first_sl = 2'd0;
    first_dw = adj0;
    if (adj0 == '0) begin
      if (adj1 != '0) begin
        first_sl = 2'd1;
        first_dw = adj1;
      end else if (adj2 != '0) begin
        first_sl = 2'd2;
        first_dw = adj2;
      end else begin
        first_ok = 1'b0;
      end
    end
  end

  logic          nxt_ok;
  logic [1:0]    nxt_sl;
  logic [DW-1:0] nxt_dw;

  always_comb begin
    nxt_ok = 1'b0;
    nxt_sl = 2'd2;
    nxt_dw = dw2;
    if (slot == 2'd0 && dw1 != '0) begin
      nxt_ok = 1'b1;
      nxt_sl = 2'd1;
      nxt_dw = dw1;
    end else if (slot != 2'd2 && dw2 != '0) begin
      nxt_ok = 1'b1;
    end
  end

  logic last, accept;
  assign last   = running && cnt == '0 && !nxt_ok;
  assign accept = load && (!running || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      slot    <= 2'd0;
      rg_q    <= 2'd0;
      cnt     <= '0;
      dw1     <= '0;
      dw2     <= '0;
      lev     <= '0;
      done    <= 1'b0;
    end else begin
      done <= last || (accept && !first_ok);
      if (accept) begin
        rg_q    <= region;
        dw1     <= adj1;
        dw2     <= adj2;
        running <= first_ok;
        slot    <= first_sl;
        cnt     <= first_dw - 1'b1;
        lev     <= first_ok ? vec_of(region, first_sl) : 6'd0;
      end else if (running) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (nxt_ok) begin
          slot <= nxt_sl;
          cnt  <= nxt_dw - 1'b1;
          lev  <= vec_of(rg_q, nxt_sl);
        end else begin
          running <= 1'b0;
          lev     <= '0;
        end
      end
    end
  end

  assign levels = lev;

  for (genvar p = 0; p < 3; p++) begin : g_phase
    assign gates[4*p +: 4] = (lev[2*p +: 2] == LP) ? 4'b1100 :
                             (lev[2*p +: 2] == LN) ? 4'b0011 : 4'b0110;
  end

endmodule

// File: rtl/npc_vector_seq_chk.sv
module npc_vector_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        running,
  input logic [5:0]  levels,
  input logic [11:0] gates
);

  p_idle_neutral_r1: assert property (@(posedge clk) disable iff (rst)
    !running |-> levels == 6'd0);

  for (genvar p = 0; p < 3; p++) begin : g_ph
    p_gate_legal_r2: assert property (@(posedge clk) disable iff (rst)
      gates[4*p +: 4] == 4'b1100 || gates[4*p +: 4] == 4'b0110 || gates[4*p +: 4] == 4'b0011);

    p_level_code_r2: assert property (@(posedge clk) disable iff (rst)
      levels[2*p +: 2] != 2'b11);

    p_no_rail_jump_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(levels[2*p +: 2]) == 2'b01 |-> levels[2*p +: 2] != 2'b10) and
      ($past(levels[2*p +: 2]) == 2'b10 |-> levels[2*p +: 2] != 2'b01));
  end

endmodule

bind npc_vector_seq npc_vector_seq_chk u_chk (
  .clk(clk), .rst(rst), .running(running), .levels(levels), .gates(gates)
);

// File: tb/npc_vector_seq_test.sv
module npc_vector_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [1:0]  region = '0;
  logic [15:0] dwell_a = '0, dwell_b = '0, dwell_c = '0, delta = '0;
  logic        np_hi = 1'b0, np_lo = 1'b0;
  logic [5:0]  levels;
  logic [11:0] gates;
  logic        done;

  always #2.5 clk = ~clk;

  npc_vector_seq uut (
    .clk(clk), .rst(rst), .load(load), .region(region),
    .dwell_a(dwell_a), .dwell_b(dwell_b), .dwell_c(dwell_c), .delta(delta),
    .np_hi(np_hi), .np_lo(np_lo), .levels(levels), .gates(gates), .done(done)
  );

  int errors = 0;
  int checks = 0;
  bit chk_on = 0;
  string tag = "R1";

  logic [5:0] q[$];
  bit exp_done = 0;
  bit m_was, m_last, m_acc;
  int m_d[3];
  int m_tot, m_lo, m_up, m_take, m_ui;

  function automatic logic [5:0] ref_vec(int rg, int k);
    logic [1:0] P = 2'b01, Z = 2'b00, N = 2'b10;
    if (k == 0) return {Z, N, Z};
    if (rg == 1) return (k == 1) ? {P, N, Z} : {P, Z, Z};
    if (rg == 2) return (k == 1) ? {P, Z, N} : {P, N, N};
    return (k == 1) ? {P, Z, Z} : {Z, Z, Z};
  endfunction

  function automatic logic [11:0] ref_gates(logic [5:0] v);
    logic [11:0] g;
    for (int p = 0; p < 3; p++)
      g[4*p +: 4] = (v[2*p +: 2] == 2'b01) ? 4'b1100 : (v[2*p +: 2] == 2'b10) ? 4'b0011 : 4'b0110;
    return g;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      exp_done = 0;
    end else begin
      m_was  = q.size() > 0;
      m_last = q.size() == 1;
      if (m_was) void'(q.pop_front());
      m_acc = load && (!m_was || m_last);
      m_tot = 0;
      if (m_acc) begin
        m_d[0] = dwell_a; m_d[1] = dwell_b; m_d[2] = dwell_c;
        if (region != 2 && (np_hi ^ np_lo)) begin
          m_ui = (region == 1) ? 2 : 1;
          m_lo = m_d[0]; m_up = m_d[m_ui];
          if (np_hi) begin
            m_take = (delta < m_up) ? int'(delta) : m_up;
            m_up -= m_take; m_lo += m_take;
          end else begin
            m_take = (delta < m_lo) ? int'(delta) : m_lo;
            m_lo -= m_take; m_up += m_take;
          end
          m_d[0] = m_lo; m_d[m_ui] = m_up;
        end
        for (int k = 0; k < 3; k++) begin
          m_tot += m_d[k];
          for (int c = 0; c < m_d[k]; c++) q.push_back(ref_vec(region, k));
        end
      end
      exp_done = m_last || (m_acc && m_tot == 0);
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      logic [5:0] ev;
      ev = (q.size() > 0) ? q[0] : 6'd0;
      checks++;
      if (levels !== ev || gates !== ref_gates(ev) || done !== exp_done) begin
        errors++;
        $display("FAIL %s: levels=%b gates=%b done=%b expected levels=%b gates=%b done=%b",
                 tag, levels, gates, done, ev, ref_gates(ev), exp_done);
      end
    end
  end

  task automatic offer(int rg, int a, int b, int c, bit hi, bit lo, int dl);
    region = rg[1:0]; dwell_a = a[15:0]; dwell_b = b[15:0]; dwell_c = c[15:0];
    np_hi = hi; np_lo = lo; delta = dl[15:0];
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic settle();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic period(int rg, int a, int b, int c, bit hi, bit lo, int dl);
    @(negedge clk);
    offer(rg, a, b, c, hi, lo, dl);
    settle();
  endtask

  task automatic chain(int rg, int a, int b, int c, bit hi, bit lo, int dl);
    while (q.size() != 1) @(negedge clk);
    offer(rg, a, b, c, hi, lo, dl);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1;
    repeat (3) @(negedge clk);

    tag = "R3"; period(0, 10, 7, 5, 0, 0, 0);
    tag = "R3"; period(3, 4, 3, 2, 0, 0, 0);
    tag = "R4"; period(1, 4, 9, 6, 0, 0, 0);
    tag = "R5"; period(2, 5, 8, 3, 1, 0, 4);
    tag = "R5"; period(2, 5, 8, 3, 0, 1, 4);
    tag = "R6"; period(1, 1, 1, 1, 0, 0, 0);
    tag = "R7"; period(0, 10, 7, 5, 1, 0, 3);
    tag = "R7"; period(1, 6, 4, 8, 1, 0, 5);
    tag = "R7"; period(0, 10, 7, 5, 1, 1, 3);
    tag = "R8"; period(1, 9, 4, 6, 0, 1, 4);
    tag = "R8"; period(0, 9, 4, 6, 0, 1, 2);
    tag = "R9"; period(0, 6, 7, 5, 1, 0, 20);
    tag = "R9"; period(1, 6, 4, 3, 0, 1, 50);
    tag = "R10"; period(1, 0, 5, 0, 0, 0, 0);
    tag = "R10"; period(2, 3, 0, 4, 0, 0, 0);
    tag = "R10"; period(0, 0, 0, 0, 0, 0, 0);
    tag = "R10"; period(1, 2, 0, 2, 1, 0, 9);

    tag = "R11";
    @(negedge clk);
    offer(0, 12, 6, 4, 0, 0, 0);
    repeat (3) @(negedge clk);
    offer(2, 2, 2, 2, 0, 0, 0);
    repeat (5) @(negedge clk);
    offer(1, 3, 3, 3, 1, 0, 1);
    settle();

    tag = "R12";
    @(negedge clk);
    offer(0, 3, 2, 2, 0, 0, 0);
    chain(1, 2, 3, 1, 0, 0, 0);
    chain(2, 1, 1, 1, 0, 0, 0);
    chain(0, 1, 1, 0, 1, 0, 1);
    chain(1, 1, 0, 0, 0, 1, 0);
    chain(0, 0, 0, 0, 0, 0, 0);
    settle();
    @(negedge clk);
    offer(2, 1, 0, 1, 0, 0, 0);
    chain(1, 5, 2, 3, 0, 1, 9);
    settle();

    tag = "R1";
    @(negedge clk);
    offer(1, 8, 8, 8, 0, 0, 0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (levels !== 6'd0 || gates !== 12'h666 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: levels=%b gates=%h done=%b expected levels=000000 gates=666 done=0",
               levels, gates, done);
    end

    tag = "R2"; period(2, 2, 3, 4, 0, 0, 0);

    summary();
  end

endmodule